// File: doc/BRIEF.md
# Distributed ID-Contention Bus Arbiter

Each device that shares a bus carries one copy of this agent. A device that wants the bus raises a start line and drives its own identifier onto a group of shared open-collector style lines, so what every agent reads back is the bitwise OR of all identifiers being driven. In each following cycle an agent looks at that OR. It finds the highest bit position where the lines show a 1 and its own identifier holds a 0. It keeps driving only the identifier bits above that position and releases everything from that position down. If no such position exists, it drives its whole identifier again. Because an agent can start driving a bit again once the conflict above it has cleared, the pattern always settles on the largest identifier that is contending.

A round lasts a fixed number of cycles, equal to the identifier width. At the end of the round every agent compares the lines with its own identifier. The one that matches asserts its grant for a single cycle. All contenders then release the lines. A loser that still wants the bus joins the next round, which can begin in the cycle after the grant. The top level connects several agents through a model of the wired-OR lines and brings those lines out so they can be observed.

Top module: `idarb_cluster`

## Requirements
- R1: While reset is held and in the first cycle after it, every grant output, every arbitration line and the start line read 0.
- R2: An agent whose request is high, whose identifier is non-zero and which sees the start line low at a rising edge enters contention at that edge. From that edge on, it drives its identifier and the start line.
- R3: An agent that is not contending drives all zeros. The observed lines are the bitwise OR of what all agents drive, so in the first contention cycle they equal the OR of the contenders' identifiers.
- R4: At each rising edge in the settling part of a round, a contender changes what it drives. It drives its identifier with every bit cleared from the highest position where the lines show 1 and its identifier shows 0 down to bit 0. If no such position exists, it drives its full identifier. Example with IDs 0101 and 0110: the lines show 0111, then 0110. Example with IDs 1010 and 0101: the lines show 1111, then 1000, then 1010.
- R5: The start line stays high for exactly ID_W cycles after the entry edge, and it is low in the cycle in which a grant is shown.
- R6: In the cycle after the round, exactly one grant is high: the grant of the contender with the numerically largest identifier. It stays high for one cycle only. Grant bit i belongs to the agent whose identifier is in dev_id[i*ID_W +: ID_W].
- R7: Identifier 0 is invalid. An agent with identifier 0 never raises the start line and never receives a grant, even when it requests.
- R8: A request that rises while a round is in progress does not join that round. It enters at the first edge at which the start line is low.
- R9: A loser that keeps its request high enters the next round at the edge that follows the grant cycle. It wins that round if it is then the largest contender.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_id | input | N_AGT*ID_W | Identifier of each agent; agent i uses bits [i*ID_W +: ID_W] |
| dev_req | input | N_AGT | Bus request of each agent |
| dev_grant | output | N_AGT | One-cycle grant pulse of each agent |
| arb_lines | output | ID_W | Wired-OR value of the identifier lines |
| arb_start | output | 1 | Wired-OR value of the start line |

## Verification
The sweeps cover every request subset over several identifier sets. These include the 1010/0101 pair, where a one-way "withdraw and never come back" agent would lock out the true winner and leave the lines at 1000 with no grant. Sets that contain identifier 0 catch a design that lets the invalid identifier raise start or take a grant when it requests alone. A request raised in the middle of a round would, in a wrong design, OR an extra identifier into the settling pattern and steal the grant. A held losing request must restart exactly one cycle after the grant, and a design with an extra idle cycle or an off-by-one window length fails the cycle-exact line and start checks.

// File: rtl/idarb_pkg.sv
package idarb_pkg;

  // contention state of one agent
  typedef enum logic {
    AG_IDLE    = 1'b0,
    AG_CONTEND = 1'b1
  } ag_state_e;

endpackage

// File: rtl/idarb_round_timer.sv
module idarb_round_timer #(
  parameter int ROUND = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic last
);
  localparam int CW = (ROUND > 1) ? $clog2(ROUND) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load || last) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + CW'(1);
    end
  end

  assign last = run && (cnt == CW'(ROUND - 1));

  // the window end is a single-cycle event, then the agent leaves
  assert_last_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !last);

endmodule

// File: rtl/idarb_agent.sv
module idarb_agent
  import idarb_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ID_W-1:0] id_in,
  input  logic            req,
  input  logic [ID_W-1:0] bus_lines,
  input  logic            bus_start,
  output logic [ID_W-1:0] drv_lines,
  output logic            drv_start,
  output logic            grant
);
  localparam int ROUND = ID_W;

  // bits at and below the highest "line 1, own 0" conflict are released
  function automatic logic [ID_W-1:0] hold_mask(input logic [ID_W-1:0] own,
                                                input logic [ID_W-1:0] lines);
    logic [ID_W-1:0] m;
    logic            hit;
    m   = '1;
    hit = 1'b0;
    for (int b = ID_W - 1; b >= 0; b--) begin
      if (!hit && lines[b] && !own[b]) hit = 1'b1;
      if (hit) m[b] = 1'b0;
    end
    return m;
  endfunction

  function automatic logic [ID_W-1:0] settle_step(input logic [ID_W-1:0] own,
                                                  input logic [ID_W-1:0] lines);
    return own & hold_mask(own, lines);
  endfunction

  ag_state_e       st;
  logic [ID_W-1:0] own_id;
  logic            entering;
  logic            contending;
  logic            round_last;
  logic            won;

  assign contending = (st == AG_CONTEND);
  assign entering   = (st == AG_IDLE) && req && (id_in != '0) && !bus_start;
  assign won        = round_last && (bus_lines == own_id) && (own_id != '0);

  idarb_round_timer #(.ROUND(ROUND)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .load (entering),
    .run  (contending),
    .last (round_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= AG_IDLE;
      own_id    <= '0;
      drv_lines <= '0;
      drv_start <= 1'b0;
      grant     <= 1'b0;
    end else begin
      grant <= 1'b0;
      unique case (st)
        AG_IDLE: begin
          if (entering) begin
            st        <= AG_CONTEND;
            own_id    <= id_in;
            drv_lines <= id_in;
            drv_start <= 1'b1;
          end
        end
        AG_CONTEND: begin
          if (round_last) begin
            st        <= AG_IDLE;
            drv_lines <= '0;
            drv_start <= 1'b0;
            grant     <= won;
          end else begin
            drv_lines <= settle_step(own_id, bus_lines);
          end
        end
        default: st <= AG_IDLE;
      endcase
    end
  end

  assert_entry_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    entering |=> (drv_start && (drv_lines == $past(id_in))));

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == AG_IDLE) |-> (drv_lines == '0 && !drv_start));

  assert_grant_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !grant);

  assert_zero_never_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (own_id != '0));

endmodule

// File: rtl/idarb_wired_or.sv
module idarb_wired_or #(
  parameter int N = 4,
  parameter int W = 4
) (
  input  logic [N*W-1:0] pats,
  input  logic [N-1:0]   flags,
  output logic [W-1:0]   lines,
  output logic           any_flag
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [N-1:0] col;
    for (genvar j = 0; j < N; j++) begin : g_src
      assign col[j] = pats[j*W + b];
    end
    assign lines[b] = |col;
  end

  assign any_flag = |flags;

endmodule

// File: rtl/idarb_cluster.sv
module idarb_cluster #(
  parameter int N_AGT = 4,
  parameter int ID_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_AGT*ID_W-1:0] dev_id,
  input  logic [N_AGT-1:0]      dev_req,
  output logic [N_AGT-1:0]      dev_grant,
  output logic [ID_W-1:0]       arb_lines,
  output logic                  arb_start
);
  localparam int BUS_W = N_AGT * ID_W;

  function automatic logic ids_distinct(input logic [BUS_W-1:0] v);
    for (int i = 0; i < N_AGT; i++)
      for (int j = i + 1; j < N_AGT; j++)
        if (v[i*ID_W +: ID_W] == v[j*ID_W +: ID_W]) return 1'b0;
    return 1'b1;
  endfunction

  logic [BUS_W-1:0] drv_bus;
  logic [N_AGT-1:0] start_bus;

  for (genvar i = 0; i < N_AGT; i++) begin : g_agt
    idarb_agent #(.ID_W(ID_W)) u_agent (
      .clk      (clk),
      .rst_n    (rst_n),
      .id_in    (dev_id[i*ID_W +: ID_W]),
      .req      (dev_req[i]),
      .bus_lines(arb_lines),
      .bus_start(arb_start),
      .drv_lines(drv_bus[i*ID_W +: ID_W]),
      .drv_start(start_bus[i]),
      .grant    (dev_grant[i])
    );
  end

  idarb_wired_or #(.N(N_AGT), .W(ID_W)) u_wor (
    .pats    (drv_bus),
    .flags   (start_bus),
    .lines   (arb_lines),
    .any_flag(arb_start)
  );

  assert_single_winner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ids_distinct(dev_id) |-> $onehot0(dev_grant));

  assert_start_low_on_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_grant) |-> !arb_start);

endmodule

// File: tb/sim_idarb_cluster.sv
module sim_idarb_cluster;
  localparam int N = 4;
  localparam int W = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N*W-1:0] dev_id = '0;
  logic [N-1:0]   dev_req = '0;
  logic [N-1:0]   dev_grant;
  logic [W-1:0]   arb_lines;
  logic           arb_start;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int ids [N];

  always #5 clk = ~clk;

  idarb_cluster #(.N_AGT(N), .ID_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .dev_id(dev_id), .dev_req(dev_req),
    .dev_grant(dev_grant), .arb_lines(arb_lines), .arb_start(arb_start)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load_ids(input int a, input int b, input int c, input int d);
    ids[0] = a; ids[1] = b; ids[2] = c; ids[3] = d;
    for (int i = 0; i < N; i++) dev_id[i*W +: W] = W'(ids[i]);
  endtask

  // one round with a one-cycle request pulse on the agents in mask
  task automatic sweep_round(input logic [N-1:0] mask);
    int best; int widx; int orv;
    best = 0; widx = -1; orv = 0;
    for (int i = 0; i < N; i++)
      if (mask[i]) begin
        orv = orv | ids[i];
        if (ids[i] > best) begin best = ids[i]; widx = i; end
      end
    @(negedge clk); dev_req = mask;
    @(negedge clk); dev_req = '0;
    if (best == 0) begin
      for (int k = 0; k < 5; k++) begin
        chk(arb_start == 1'b0, "R7 start stays low", int'(arb_start), 0);
        chk(dev_grant == '0, "R7 no grant", int'(dev_grant), 0);
        @(negedge clk);
      end
    end else begin
      chk(arb_start == 1'b1, "R2 start raised", int'(arb_start), 1);
      chk(int'(arb_lines) == orv, "R3 first lines are OR", int'(arb_lines), orv);
      for (int k = 0; k < W - 1; k++) begin
        @(negedge clk);
        chk(arb_start == 1'b1, "R5 start held", int'(arb_start), 1);
      end
      chk(int'(arb_lines) == best, "R4 lines settle to max", int'(arb_lines), best);
      @(negedge clk);
      chk(int'(dev_grant) == (1 << widx), "R6 winner grant", int'(dev_grant), 1 << widx);
      chk(arb_start == 1'b0, "R5 start dropped", int'(arb_start), 0);
      @(negedge clk);
      chk(dev_grant == '0, "R6 grant one cycle", int'(dev_grant), 0);
    end
  endtask

  // two contenders agents 0 and 1, hand-worked line trace
  task automatic trace_pair(input int t0, input int t1, input int t2, input int win);
    @(negedge clk); dev_req = 4'b0011;
    @(negedge clk); dev_req = '0;
    chk(int'(arb_lines) == t0, "R4 trace step0", int'(arb_lines), t0);
    @(negedge clk);
    chk(int'(arb_lines) == t1, "R4 trace step1", int'(arb_lines), t1);
    @(negedge clk);
    chk(int'(arb_lines) == t2, "R4 trace step2", int'(arb_lines), t2);
    @(negedge clk);
    @(negedge clk);
    chk(int'(dev_grant) == win, "R6 trace winner", int'(dev_grant), win);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    load_ids(5, 6, 9, 3);
    repeat (3) @(negedge clk);
    chk(dev_grant == '0, "R1 reset grant", int'(dev_grant), 0);
    chk(arb_lines == '0, "R1 reset lines", int'(arb_lines), 0);
    chk(arb_start == 1'b0, "R1 reset start", int'(arb_start), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(arb_start == 1'b0 && dev_grant == '0, "R1 after reset", int'(arb_start), 0);

    // R4: 0101 vs 0110 and 1010 vs 0101
    load_ids(5, 6, 9, 3);
    trace_pair(7, 6, 6, 2);
    load_ids(10, 5, 1, 15);
    trace_pair(15, 8, 10, 1);

    // sweeps over all request subsets, several identifier sets (R2..R7)
    for (int s = 0; s < 5; s++) begin
      case (s)
        0: load_ids(5, 6, 9, 3);
        1: load_ids(10, 5, 1, 15);
        2: load_ids(0, 12, 8, 4);
        3: load_ids(1, 2, 4, 8);
        default: load_ids(7, 14, 13, 11);
      endcase
      for (int m = 1; m < 16; m++) sweep_round(N'(m));
    end

    // R8: late request waits for the next round
    load_ids(5, 6, 9, 3);
    @(negedge clk); dev_req = 4'b1000;
    @(negedge clk); dev_req = 4'b0000;
    @(negedge clk); dev_req = 4'b0100;
    @(negedge clk);
    chk(int'(arb_lines) == 3, "R8 no mid-round join", int'(arb_lines), 3);
    @(negedge clk);
    chk(int'(arb_lines) == 3, "R8 lines unchanged", int'(arb_lines), 3);
    @(negedge clk);
    chk(int'(dev_grant) == 8, "R8 first round winner", int'(dev_grant), 8);
    @(negedge clk); dev_req = '0;
    chk(arb_start == 1'b1 && int'(arb_lines) == 9, "R8 late entry", int'(arb_lines), 9);
    repeat (4) @(negedge clk);
    chk(int'(dev_grant) == 4, "R8 late winner", int'(dev_grant), 4);
    @(negedge clk);

    // R9: loser keeps requesting and retries at once
    @(negedge clk); dev_req = 4'b0011;
    repeat (5) @(negedge clk);
    chk(int'(dev_grant) == 2, "R9 first winner", int'(dev_grant), 2);
    dev_req = 4'b0001;
    @(negedge clk); dev_req = '0;
    chk(arb_start == 1'b1 && int'(arb_lines) == 5, "R9 retry entry", int'(arb_lines), 5);
    repeat (4) @(negedge clk);
    chk(int'(dev_grant) == 1, "R9 retry winner", int'(dev_grant), 1);
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule